// File: doc/BRIEF.md
# RTC Interrupt Emulation Engine

This block recreates the three classic real-time-clock interrupt sources (seconds update, time-of-day alarm and programmable periodic) on top of a free-running counter and a single one-shot compare channel. It keeps one compare value. Each time the counter reaches that value, the block reschedules the next compare by whole tick intervals until the compare is ahead of the counter again. It then evaluates the enabled sources and presents a flags word on a one-cycle strobe.

The base tick runs at 64 Hz. When a periodic rate above 64 Hz is programmed and the periodic source is enabled, the tick interval shrinks to match that rate. At 64 Hz or below, the tick stays at 64 Hz and a divider thins the periodic flags. The counter frequency is a power of two, 2^CNT_LOG2 counts per second, so every interval is a shift of one. A tick that is detected late does not replay the ticks it missed. They are counted as lost, and the count is added to the periodic divider. The number of compare advances made per tick is bounded, so a very long gap is worked off over several short rounds instead of one long stall.

Top module: `rtc_irq_emu`

## Requirements
- R1: After reset, irq_valid is 0, irq_word is 0 and no strobe appears until a source is enabled.
- R2: irq_word is all zero except while irq_valid is high, and irq_valid is never high on two consecutive cycles. A strobed word carries bit 4 = update, bit 5 = alarm, bit 6 = periodic, bit 7 = pending (always 1), bits [15:8] = 1 and bits [3:0] = 0. A strobe is issued only when at least one source flag is set.
- R3: At a rate exponent e of 6 or less (rate 2^e Hz), the tick interval is 2^(CNT_LOG2-6) counts and a periodic flag is raised every 2^(6-e) ticks. Counting starts when the periodic source is enabled.
- R4: At a rate exponent e from 7 to 13, with the periodic source enabled, the tick interval is 2^(CNT_LOG2-e) counts and every tick raises a periodic flag.
- R5: After reset the rate exponent is 6, which gives a periodic flag on every 64 Hz tick. A rate write whose exponent lies outside 1..13 leaves the rate unchanged.
- R6: On a tick, the compare is advanced by the interval until the signed 32-bit difference (compare - counter) is positive. Each advance after the first is a lost tick, and the lost ticks are added to the periodic count before that tick's own increment.
- R7: One tick makes at most MAX_CATCH advances. If the compare is still behind after that, the tick completes and a new tick starts at once, until the schedule has caught up. After catch-up, ticks return to the normal spacing.
- R8: With the update source enabled, a tick that sees a seconds value different from the stored one raises the update flag and stores the new value. The first tick after the update source becomes enabled only stores the value and raises no flag.
- R9: With the alarm source enabled, a tick on which hours, minutes and seconds all equal the programmed alarm time raises the alarm flag.
- R10: The enable mask is bit 0 = update, bit 1 = alarm, bit 2 = periodic. Writing an all-zero mask stops the compare channel, and no strobe appears from two cycles after that write. Writing a non-zero mask from the all-zero state arms the first compare at counter + interval.
- R11: A source whose enable bit is clear raises no flag, even when its condition is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_in | input | CNT_W | Free-running counter at 2^CNT_LOG2 counts per second |
| tod_hr | input | TOD_W | Current hours |
| tod_min | input | TOD_W | Current minutes |
| tod_sec | input | TOD_W | Current seconds |
| en_we | input | 1 | Enable-mask write strobe |
| en_wdata | input | 3 | New enable mask (bit 0 update, bit 1 alarm, bit 2 periodic) |
| alm_we | input | 1 | Alarm-time write strobe |
| alm_hr | input | TOD_W | Alarm hours |
| alm_min | input | TOD_W | Alarm minutes |
| alm_sec | input | TOD_W | Alarm seconds |
| rate_we | input | 1 | Periodic-rate write strobe |
| rate_exp | input | 4 | Periodic rate as a power-of-two exponent (1..13) |
| irq_valid | output | 1 | One-cycle strobe for a new flags word |
| irq_word | output | 16 | Flags word, zero when not strobed |

## Verification
The bench jumps the counter forward past several compare points. A design that ignored lost ticks would delay the next periodic flag by the skipped intervals. A design with an unbounded catch-up would emit a single flag after one long pass instead of a quick burst of rounds. Seconds changes are placed around fresh enables of the update source, so an engine that forgot the invalid marker would raise a spurious update on the first tick. Rate writes with exponents 0 and 15 are issued while the fast rate is running, and alarm matches are presented with the alarm source off. A design that accepted those writes or ignored the enable bit would change the flag spacing or produce strobes that the scoreboard does not expect.

// File: rtl/rtc_emu_pkg.sv
`timescale 1ns/1ps
package rtc_emu_pkg;
    localparam int EN_W   = 3;
    localparam int EN_UPD = 0;
    localparam int EN_ALM = 1;
    localparam int EN_PER = 2;

    localparam int FLG_UPD  = 4;
    localparam int FLG_ALM  = 5;
    localparam int FLG_PER  = 6;
    localparam int FLG_PEND = 7;
    localparam int WORD_W   = 16;

    localparam logic [3:0] BASE_EXP = 4'd6;   // 64 Hz base tick
    localparam logic [3:0] MIN_EXP  = 4'd1;   // 2 Hz
    localparam logic [3:0] MAX_EXP  = 4'd13;  // 8192 Hz

    typedef enum logic [1:0] {SC_OFF, SC_WAIT, SC_STEP} sched_e;
endpackage

// File: rtl/rtc_emu_rate.sv
`timescale 1ns/1ps
// Holds the programmed periodic rate and derives tick intervals and divider limit.
module rtc_emu_rate
    import rtc_emu_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int CNT_LOG2 = 15,   // must be at least 13
    parameter int DIV_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_we,
    input  logic [3:0]       rate_exp,
    output logic [CNT_W-1:0] base_ivl,
    output logic [CNT_W-1:0] fast_ivl,
    output logic [DIV_W-1:0] div_limit,
    output logic             fast_mode
);
    localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
    localparam logic [5:0]       LOG2_C   = 6'(CNT_LOG2);
    localparam logic [CNT_W-1:0] BASE_IVL = ONE_C << (LOG2_C - {2'b00, BASE_EXP});

    typedef struct packed {
        logic [3:0] exp;
    } rate_t;

    rate_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rate_we && rate_exp >= MIN_EXP && rate_exp <= MAX_EXP) begin
            r_d.exp = rate_exp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.exp <= BASE_EXP;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        fast_mode = (r_q.exp > BASE_EXP);
        base_ivl  = BASE_IVL;
        fast_ivl  = ONE_C << (LOG2_C - {2'b00, r_q.exp});
        if (fast_mode) begin
            div_limit = '0;
        end else begin
            div_limit = DIV_W'(1) << (BASE_EXP - r_q.exp);
        end
    end
endmodule

// File: rtl/rtc_emu_sched.sv
`timescale 1ns/1ps
// Enable mask, compare value and bounded catch-up sequencer.
module rtc_emu_sched
    import rtc_emu_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int MAX_CATCH = 16,
    parameter int LOST_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              en_we,
    input  logic [EN_W-1:0]   en_wdata,
    input  logic [CNT_W-1:0]  base_ivl,
    input  logic [CNT_W-1:0]  fast_ivl,
    input  logic              fast_mode,
    output logic [EN_W-1:0]   en_cur,
    output logic [EN_W-1:0]   en_rise,
    output logic              tick,
    output logic [LOST_W-1:0] lost
);
    localparam logic [LOST_W-1:0] LAST_ITER = LOST_W'(MAX_CATCH - 1);

    typedef struct packed {
        sched_e              st;
        logic [CNT_W-1:0]    cmp;
        logic [LOST_W-1:0]   iter;
        logic [EN_W-1:0]     en;
        logic [EN_W-1:0]     rise;
        logic                tick;
        logic [LOST_W-1:0]   lost;
    } sched_t;

    sched_t s_d, s_q;

    logic [CNT_W-1:0] ivl_cur, ivl_new, nxt, lag, lead;
    logic             ahead;

    always_comb begin
        ivl_cur = (s_q.en[EN_PER] && fast_mode) ? fast_ivl : base_ivl;
        ivl_new = (en_wdata[EN_PER] && fast_mode) ? fast_ivl : base_ivl;
        nxt     = s_q.cmp + ivl_cur;
        lag     = cnt_in - s_q.cmp;
        lead    = nxt - cnt_in;
        ahead   = !lead[CNT_W-1] && (lead != '0);
    end

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        s_d.lost = '0;
        s_d.rise = '0;
        unique case (s_q.st)
            SC_WAIT: begin
                if (!lag[CNT_W-1]) begin
                    s_d.st   = SC_STEP;
                    s_d.iter = '0;
                end
            end
            SC_STEP: begin
                s_d.cmp = nxt;
                if (ahead || s_q.iter == LAST_ITER) begin
                    s_d.tick = 1'b1;
                    s_d.lost = s_q.iter;
                    s_d.st   = SC_WAIT;
                end else begin
                    s_d.iter = s_q.iter + 1'b1;
                end
            end
            default: ;
        endcase
        if (en_we) begin
            s_d.en   = en_wdata;
            s_d.rise = en_wdata & ~s_q.en;
            if (en_wdata == '0) begin
                s_d.st   = SC_OFF;
                s_d.tick = 1'b0;
                s_d.lost = '0;
            end else if (s_q.en == '0) begin
                s_d.st  = SC_WAIT;
                s_d.cmp = cnt_in + ivl_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= SC_OFF;
            s_q.cmp  <= '0;
            s_q.iter <= '0;
            s_q.en   <= '0;
            s_q.rise <= '0;
            s_q.tick <= 1'b0;
            s_q.lost <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_cur  = s_q.en;
    assign en_rise = s_q.rise;
    assign tick    = s_q.tick;
    assign lost    = s_q.lost;
endmodule

// File: rtl/rtc_emu_eval.sv
`timescale 1ns/1ps
// Per-tick evaluation of update, alarm and periodic sources.
module rtc_emu_eval
    import rtc_emu_pkg::*;
#(
    parameter int TOD_W  = 8,
    parameter int DIV_W  = 8,
    parameter int LOST_W = 4,
    parameter int PIE_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [LOST_W-1:0] lost,
    input  logic [EN_W-1:0]   en_cur,
    input  logic [EN_W-1:0]   en_rise,
    input  logic [DIV_W-1:0]  div_limit,
    input  logic [TOD_W-1:0]  tod_hr,
    input  logic [TOD_W-1:0]  tod_min,
    input  logic [TOD_W-1:0]  tod_sec,
    input  logic              alm_we,
    input  logic [TOD_W-1:0]  alm_hr,
    input  logic [TOD_W-1:0]  alm_min,
    input  logic [TOD_W-1:0]  alm_sec,
    output logic              irq_valid,
    output logic [WORD_W-1:0] irq_word
);
    typedef struct packed {
        logic [TOD_W-1:0]  prev_sec;
        logic              prev_ok;
        logic [TOD_W-1:0]  a_hr;
        logic [TOD_W-1:0]  a_min;
        logic [TOD_W-1:0]  a_sec;
        logic [PIE_W-1:0]  pie;
        logic              valid;
        logic [WORD_W-1:0] word;
    } eval_t;

    eval_t e_d, e_q;
    logic [7:0]       flags;
    logic [PIE_W-1:0] pie_sum;
    logic             alarm_hit;

    always_comb begin
        alarm_hit = (tod_hr == e_q.a_hr) && (tod_min == e_q.a_min) && (tod_sec == e_q.a_sec);
    end

    always_comb begin
        e_d       = e_q;
        e_d.valid = 1'b0;
        e_d.word  = '0;
        flags     = '0;
        pie_sum   = '0;
        if (alm_we) begin
            e_d.a_hr  = alm_hr;
            e_d.a_min = alm_min;
            e_d.a_sec = alm_sec;
        end
        if (en_rise[EN_UPD]) e_d.prev_ok = 1'b0;
        if (en_rise[EN_PER]) e_d.pie     = '0;
        if (tick) begin
            if (en_cur[EN_UPD] && (!e_d.prev_ok || tod_sec != e_q.prev_sec)) begin
                flags[FLG_UPD] = e_d.prev_ok;
                e_d.prev_sec   = tod_sec;
                e_d.prev_ok    = 1'b1;
            end
            if (en_cur[EN_ALM] && alarm_hit) begin
                flags[FLG_ALM] = 1'b1;
            end
            if (en_cur[EN_PER]) begin
                pie_sum = e_d.pie + PIE_W'(lost) + PIE_W'(1);
                if (pie_sum >= PIE_W'(div_limit)) begin
                    flags[FLG_PER] = 1'b1;
                    e_d.pie        = '0;
                end else begin
                    e_d.pie = pie_sum;
                end
            end
            if (flags != '0) begin
                flags[FLG_PEND] = 1'b1;
                e_d.valid       = 1'b1;
                e_d.word        = {8'd1, flags};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q.prev_sec <= '0;
            e_q.prev_ok  <= 1'b0;
            e_q.a_hr     <= '0;
            e_q.a_min    <= '0;
            e_q.a_sec    <= '0;
            e_q.pie      <= '0;
            e_q.valid    <= 1'b0;
            e_q.word     <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign irq_valid = e_q.valid;
    assign irq_word  = e_q.word;
endmodule

// File: rtl/rtc_irq_emu.sv
`timescale 1ns/1ps
module rtc_irq_emu
    import rtc_emu_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int CNT_LOG2  = 15,
    parameter int TOD_W     = 8,
    parameter int MAX_CATCH = 16,
    parameter int PIE_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [TOD_W-1:0]  tod_hr,
    input  logic [TOD_W-1:0]  tod_min,
    input  logic [TOD_W-1:0]  tod_sec,
    input  logic              en_we,
    input  logic [2:0]        en_wdata,
    input  logic              alm_we,
    input  logic [TOD_W-1:0]  alm_hr,
    input  logic [TOD_W-1:0]  alm_min,
    input  logic [TOD_W-1:0]  alm_sec,
    input  logic              rate_we,
    input  logic [3:0]        rate_exp,
    output logic              irq_valid,
    output logic [15:0]       irq_word
);
    localparam int LOST_W = (MAX_CATCH > 2) ? $clog2(MAX_CATCH) : 1;
    localparam int DIV_W  = 8;

    logic [CNT_W-1:0]  base_ivl, fast_ivl;
    logic [DIV_W-1:0]  div_limit;
    logic              fast_mode;
    logic [EN_W-1:0]   en_cur, en_rise;
    logic              tick;
    logic [LOST_W-1:0] lost;

    rtc_emu_rate #(.CNT_W(CNT_W), .CNT_LOG2(CNT_LOG2), .DIV_W(DIV_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_exp(rate_exp),
        .base_ivl(base_ivl), .fast_ivl(fast_ivl), .div_limit(div_limit), .fast_mode(fast_mode)
    );

    rtc_emu_sched #(.CNT_W(CNT_W), .MAX_CATCH(MAX_CATCH), .LOST_W(LOST_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .en_we(en_we), .en_wdata(en_wdata),
        .base_ivl(base_ivl), .fast_ivl(fast_ivl), .fast_mode(fast_mode),
        .en_cur(en_cur), .en_rise(en_rise), .tick(tick), .lost(lost)
    );

    rtc_emu_eval #(.TOD_W(TOD_W), .DIV_W(DIV_W), .LOST_W(LOST_W), .PIE_W(PIE_W)) u_eval (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lost(lost), .en_cur(en_cur), .en_rise(en_rise),
        .div_limit(div_limit), .tod_hr(tod_hr), .tod_min(tod_min), .tod_sec(tod_sec),
        .alm_we(alm_we), .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec),
        .irq_valid(irq_valid), .irq_word(irq_word)
    );
endmodule

// File: rtl/rtc_emu_chk.sv
`timescale 1ns/1ps
module rtc_emu_chk
    import rtc_emu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            irq_valid,
    input logic [15:0]     irq_word,
    input logic            en_we,
    input logic [EN_W-1:0] en_wdata,
    input logic [EN_W-1:0] en_cur,
    input logic            tick
);
    // R2: strobed word layout
    p_word_format_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_word[15:8] == 8'd1 && irq_word[FLG_PEND] &&
                       irq_word[FLG_PER:FLG_UPD] != 3'b000 && irq_word[3:0] == 4'd0));

    // R2: word is zero between strobes
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> irq_word == 16'd0);

    // R2: strobe lasts one cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    // R10: all-clear write silences the output two cycles later
    p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && en_wdata == '0) |-> ##2 !irq_valid);

    // R10: sequencer ticks only while some source is enabled
    p_tick_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en_cur != '0);

    // R11: each flag needs its source enabled on the evaluating tick
    p_src_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ((!irq_word[FLG_UPD] || $past(en_cur[EN_UPD])) &&
                       (!irq_word[FLG_ALM] || $past(en_cur[EN_ALM])) &&
                       (!irq_word[FLG_PER] || $past(en_cur[EN_PER]))));
endmodule

bind rtc_irq_emu rtc_emu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_word(irq_word),
    .en_we(en_we), .en_wdata(en_wdata), .en_cur(en_cur), .tick(tick)
);

// File: tb/rtc_irq_emu_tb.sv
`timescale 1ns/1ps
module rtc_irq_emu_tb;
    localparam int CNT_W     = 32;
    localparam int CNT_LOG2  = 13;
    localparam int TOD_W     = 8;
    localparam int MAX_CATCH = 4;
    localparam int BASE      = 128;   // 2^(13-6)

    localparam logic [15:0] W_PER = 16'h01C0;
    localparam logic [15:0] W_UPD = 16'h0190;
    localparam logic [15:0] W_ALM = 16'h01A0;
    localparam logic [15:0] W_UA  = 16'h01B0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [CNT_W-1:0] cnt = '0;
    logic             jump = 1'b0;
    logic [CNT_W-1:0] jump_amt = '0;
    always @(posedge clk) cnt <= jump ? cnt + jump_amt : cnt + 1;

    logic [TOD_W-1:0] tod_hr = '0, tod_min = '0, tod_sec = '0;
    logic             en_we = 1'b0;
    logic [2:0]       en_wdata = '0;
    logic             alm_we = 1'b0;
    logic [TOD_W-1:0] alm_hr = '0, alm_min = '0, alm_sec = '0;
    logic             rate_we = 1'b0;
    logic [3:0]       rate_exp = '0;
    logic             irq_valid;
    logic [15:0]      irq_word;

    rtc_irq_emu #(.CNT_W(CNT_W), .CNT_LOG2(CNT_LOG2), .TOD_W(TOD_W), .MAX_CATCH(MAX_CATCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt), .tod_hr(tod_hr), .tod_min(tod_min), .tod_sec(tod_sec),
        .en_we(en_we), .en_wdata(en_wdata), .alm_we(alm_we), .alm_hr(alm_hr), .alm_min(alm_min),
        .alm_sec(alm_sec), .rate_we(rate_we), .rate_exp(rate_exp),
        .irq_valid(irq_valid), .irq_word(irq_word)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    typedef struct {
        logic [15:0] w;
        string       tag;
    } exp_t;

    exp_t             sb_q[$];
    bit               free_mode = 1'b0;
    logic [15:0]      free_word = '0;
    int               vcount = 0;
    logic [CNT_W-1:0] vcnt_last = '0, vcnt_prev = '0;

    // monitor: pop and compare on every strobe
    always @(negedge clk) begin
        if (rst_n && irq_valid) begin
            vcount++;
            vcnt_prev = vcnt_last;
            vcnt_last = cnt;
            if (free_mode) begin
                check(irq_word == free_word, "R7", "burst word", irq_word, free_word);
            end else if (sb_q.size() == 0) begin
                check(1'b0, "R11", "unexpected strobe", irq_word, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(irq_word == e.w, e.tag, "flags word", irq_word, e.w);
            end
        end
    end

    logic [CNT_W-1:0] arm_cnt = '0;

    task automatic expect_word(input logic [15:0] w, input string tag, input int n);
        for (int i = 0; i < n; i++) sb_q.push_back('{w: w, tag: tag});
    endtask

    task automatic set_en(input logic [2:0] m);
        @(negedge clk); en_we = 1'b1; en_wdata = m; arm_cnt = cnt;
        @(negedge clk); en_we = 1'b0;
    endtask

    task automatic set_rate(input logic [3:0] e);
        @(negedge clk); rate_we = 1'b1; rate_exp = e;
        @(negedge clk); rate_we = 1'b0;
    endtask

    task automatic set_alarm(input int h, input int m, input int s);
        @(negedge clk); alm_we = 1'b1;
        alm_hr = TOD_W'(h); alm_min = TOD_W'(m); alm_sec = TOD_W'(s);
        @(negedge clk); alm_we = 1'b0;
    endtask

    task automatic do_jump(input int a);
        @(negedge clk); jump = 1'b1; jump_amt = CNT_W'(a);
        @(negedge clk); jump = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_v(input int n);
        int target;
        target = vcount + n;
        while (vcount < target) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R1 watchdog expired: actual 0x%0h expected 0x%0h", vcount, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int v0;
        logic [CNT_W-1:0] e0;

        // R1: reset state
        idle(5);
        check(irq_valid == 1'b0, "R1", "valid in reset", irq_valid, 0);
        check(irq_word == 16'd0, "R1", "word in reset", irq_word, 0);
        rst_n = 1'b1;
        idle(300);
        check(vcount == 0, "R1", "quiet before enable", vcount, 0);

        // R5: reset rate is 64 Hz, a periodic flag on every tick
        expect_word(W_PER, "R5", 3);
        set_en(3'b100);
        wait_v(3);
        check(vcnt_last - vcnt_prev == BASE, "R5", "reset-rate spacing", vcnt_last - vcnt_prev, BASE);
        set_en(3'b000);
        v0 = vcount;
        idle(400);
        check(vcount == v0, "R10", "no strobe after all-clear", vcount, v0);

        // R3: 32 Hz -> flag every second 64 Hz tick
        set_rate(4'd5);
        expect_word(W_PER, "R3", 3);
        set_en(3'b100);
        e0 = arm_cnt;
        wait_v(1);
        check((vcnt_last - e0) >= 2*BASE && (vcnt_last - e0) <= 2*BASE + 4, "R3",
              "first flag after two ticks", vcnt_last - e0, 2*BASE);
        check((vcnt_last - e0) >= BASE, "R10", "first compare at counter+interval", vcnt_last - e0, 2*BASE);
        wait_v(2);
        check(vcnt_last - vcnt_prev == 2*BASE, "R3", "divided spacing", vcnt_last - vcnt_prev, 2*BASE);
        set_en(3'b000);

        // R4: 128 Hz -> interval 64 counts, flag every tick
        set_rate(4'd7);
        expect_word(W_PER, "R4", 3);
        set_en(3'b100);
        wait_v(3);
        check(vcnt_last - vcnt_prev == BASE/2, "R4", "fast spacing", vcnt_last - vcnt_prev, BASE/2);

        // R5: out-of-range exponents ignored
        set_rate(4'd0);
        set_rate(4'd15);
        expect_word(W_PER, "R5", 2);
        wait_v(2);
        check(vcnt_last - vcnt_prev == BASE/2, "R5", "spacing after bad rate writes", vcnt_last - vcnt_prev, BASE/2);
        set_en(3'b000);

        // R6: lost ticks feed the divider (16 Hz, limit 4)
        set_rate(4'd4);
        expect_word(W_PER, "R6", 1);
        set_en(3'b100);
        e0 = arm_cnt;
        do_jump(3*BASE + 10);
        wait_v(1);
        check((vcnt_last - e0) >= 4*BASE && (vcnt_last - e0) <= 4*BASE + 4, "R6",
              "flag after catch-up credit", vcnt_last - e0, 4*BASE);
        set_en(3'b000);

        // R7: bounded catch-up after a long gap
        set_rate(4'd6);
        free_mode = 1'b1;
        free_word = W_PER;
        set_en(3'b100);
        do_jump(20*BASE);
        v0 = vcount;
        idle(60);
        check((vcount - v0) >= 3, "R7", "catch-up burst rounds", vcount - v0, 3);
        idle(200);
        wait_v(2);
        check(vcnt_last - vcnt_prev == BASE, "R7", "normal spacing after catch-up", vcnt_last - vcnt_prev, BASE);
        free_mode = 1'b0;
        set_en(3'b000);

        // R8: update source
        tod_hr = 8'd1; tod_min = 8'd2; tod_sec = 8'd10;
        set_alarm(5, 5, 5);
        set_en(3'b001);
        v0 = vcount;
        idle(300);
        check(vcount == v0, "R8", "first tick records only", vcount, v0);
        expect_word(W_UPD, "R8", 1);
        tod_sec = 8'd11;
        wait_v(1);
        idle(300);
        expect_word(W_UPD, "R8", 1);
        tod_sec = 8'd12;
        wait_v(1);
        set_en(3'b000);
        tod_sec = 8'd13;
        set_en(3'b001);
        v0 = vcount;
        idle(300);
        check(vcount == v0, "R8", "suppressed after re-enable", vcount, v0);
        expect_word(W_UPD, "R8", 1);
        tod_sec = 8'd14;
        wait_v(1);

        // R11: alarm matches while only update is enabled
        set_alarm(1, 2, 14);
        v0 = vcount;
        idle(300);
        check(vcount == v0, "R11", "disabled alarm silent", vcount, v0);
        set_en(3'b000);

        // R9: alarm source
        set_alarm(1, 2, 15);
        set_en(3'b010);
        v0 = vcount;
        idle(300);
        check(vcount == v0, "R9", "no alarm on mismatch", vcount, v0);
        expect_word(W_ALM, "R9", 2);
        tod_sec = 8'd15;
        wait_v(2);
        tod_sec = 8'd16;
        v0 = vcount;
        idle(300);
        check(vcount == v0, "R9", "alarm stops after mismatch", vcount, v0);
        set_en(3'b000);

        // R8 + R9 combined
        set_en(3'b011);
        idle(300);
        set_alarm(1, 2, 17);
        expect_word(W_UA, "R9", 1);
        expect_word(W_ALM, "R9", 1);
        tod_sec = 8'd17;
        wait_v(2);
        expect_word(W_UPD, "R8", 1);
        tod_sec = 8'd18;
        wait_v(1);
        set_en(3'b000);

        idle(50);
        check(sb_q.size() == 0, "R2", "all expected words seen", sb_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule